// File: doc/BRIEF.md
# Byte-Exchange Serial Peripheral Master with Clock Mode Selection

This block is a serial peripheral master that swaps one byte with a single attached slave on each transfer. It drives the serial clock, the master-to-slave data line and an active-low chip-select, and it samples the slave-to-master data line. The whole exchange runs through one shift register. Each clock cycle on the wire moves one transmit bit out of the top of the register, most significant bit first, and moves one receive bit into the bottom.

Runtime inputs set three things: the clock idle level (polarity), which clock edge samples data (phase), and a divider that sets the length of each half-period of the serial clock in system clocks. These settings are captured when a transfer is accepted. The outgoing byte arrives on a valid/ready stream port. The master raises `tx_ready_o` only while it is idle, so the upstream source is held back for the whole transfer. The received byte leaves on a valid-only port: `rx_valid_o` pulses for one system clock, and it cannot be held back, because the serial protocol has no flow control. Nothing addresses the slave except the select line, and nothing on the wire acknowledges data, so every transfer that starts runs to completion.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset and whenever idle, `csel_n_o` is 1, `tx_ready_o` is 1, `rx_valid_o` is 0, and `sclk_o` follows `pol_i` (0 idles low, 1 idles high).
- R2: A transfer is accepted on a clock where `tx_valid_i` and `tx_ready_o` are both 1. From the next clock until the transfer ends, `tx_ready_o` is 0 and `csel_n_o` is 0, and `tx_valid_i` and `tx_data_i` are ignored.
- R3: The sampling edge follows this table with (pol, pha): (0,0) rising, (0,1) falling, (1,0) falling, (1,1) rising. The master samples `miso_i` on that edge and changes `mosi_o` only on the opposite edge.
- R4: Data is full duplex and MSB first. The slave sees bits 7 down to 0 of the accepted byte on `mosi_o`. `rx_data_o` holds the eight `miso_i` bits in arrival order, the first one at bit 7.
- R5: Each transfer makes exactly 16 `sclk_o` transitions (8 sampling edges). Each half-period lasts `clk_div_i`+1 system clocks. `sclk_o` ends at the idle level.
- R6: With pha=0, `mosi_o` shows bit 7 of the byte from the first clock in which `csel_n_o` is 0, before any `sclk_o` edge.
- R7: `csel_n_o` rises `clk_div_i`+1 clocks after the last edge, that is 17*(`clk_div_i`+1) clocks after acceptance. On the same clock `rx_valid_o` is 1 for exactly one cycle, with `rx_data_o` valid.
- R8: Polarity, phase and divider are captured at acceptance. Changing `pol_i`, `pha_i` or `clk_div_i` during a transfer does not change its timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_i | input | 1 | Serial clock idle level |
| pha_i | input | 1 | 0: sample on the first edge of each bit; 1: sample on the second edge |
| clk_div_i | input | DIV_W | Half-period length minus one, in system clocks |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Master idle and able to accept a byte |
| tx_data_i | input | DATA_W | Byte to send |
| rx_valid_o | output | 1 | One-cycle pulse: received byte valid |
| rx_data_o | output | DATA_W | Received byte |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Master-to-slave data |
| miso_i | input | 1 | Slave-to-master data |
| csel_n_o | output | 1 | Active-low chip-select |

## Verification
A behavioural slave in the bench decodes the sampling edge from the mode table on its own. For every polarity/phase pair it exchanges bytes such as all-zeros, all-ones, alternating bits and single set bits at either end. Alternating and single-bit patterns expose bit-order and off-by-one shift errors, and a wrong edge choice shows up as a shifted or corrupted byte on both sides. Several divider values check the transfer length against 17*(divider+1). Some transfers change the mode and divider inputs and offer a new byte while busy, to show that the captured settings hold for the whole transfer.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;

  typedef struct packed {
    logic pol;
    logic pha;
  } spi_mode_t;

  // Mode table: sampling edge is rising when polarity and phase agree.
  function automatic logic samples_on_rising(spi_mode_t m);
    return ~(m.pol ^ m.pha);
  endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R5: the counter never passes the captured limit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));

endmodule

// File: rtl/spi_phase_ctrl.sv
module spi_phase_ctrl
  import spi_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      run,
  input  logic      tick,
  input  logic      pol_live,
  input  spi_mode_t mode,
  output logic      sclk_o,
  output logic      launch,
  output logic      sample,
  output logic      finish
);

  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES + 1);

  logic [CNT_W-1:0] edge_cnt_q;
  logic             sclk_q;
  logic             more, leading, last;

  assign more    = edge_cnt_q < CNT_W'(EDGES);
  assign leading = ~edge_cnt_q[0];
  assign last    = edge_cnt_q == CNT_W'(EDGES - 1);

  assign launch = tick && more && (mode.pha ? leading : (!leading && !last));
  assign sample = tick && more && (mode.pha ? !leading : leading);
  assign finish = tick && !more;
  assign sclk_o = run ? sclk_q : pol_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      edge_cnt_q <= '0;
    end else if (start) begin
      sclk_q     <= pol_live;
      edge_cnt_q <= '0;
    end else if (!run) begin
      sclk_q     <= pol_live;
    end else if (tick && more) begin
      sclk_q     <= ~sclk_q;
      edge_cnt_q <= edge_cnt_q + 1'b1;
    end
  end

  // R3: after a sampling edge the clock level matches the mode table
  p_sample_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> (sclk_q == samples_on_rising(mode)));

  // R5: the clock only moves on divider ticks
  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sclk_q));

  // R5: the clock is back at its idle level when the transfer closes
  p_idle_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (sclk_q == mode.pol));

  p_edge_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt_q <= CNT_W'(EDGES));

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              early,
  input  logic [DATA_W-1:0] load_data,
  input  logic              launch,
  input  logic              sample,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] shreg_o
);

  logic [DATA_W-1:0] sh_q;
  logic              mosi_q;

  assign mosi_o  = mosi_q;
  assign shreg_o = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      if (early) begin
        mosi_q <= load_data[DATA_W-1];
        sh_q   <= {load_data[DATA_W-2:0], 1'b0};
      end else begin
        mosi_q <= 1'b0;
        sh_q   <= load_data;
      end
    end else if (launch) begin
      mosi_q <= sh_q[DATA_W-1];
      sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
    end else if (sample) begin
      sh_q   <= {sh_q[DATA_W-1:1], miso_i};
    end
  end

  // R4: a bit is never launched and captured on the same edge
  p_shift_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && sample));

  // R3: the output line holds between launch events
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !load) |=> $stable(mosi_q));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_mode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pol_i,
  input  logic              pha_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              csel_n_o
);

  logic             busy_q, csel_n_q, rx_valid_q;
  spi_mode_t        mode_q;
  logic [DIV_W-1:0] div_q;
  logic             accept, tick, launch, sample, finish;

  assign accept     = tx_valid_i && !busy_q;
  assign tx_ready_o = !busy_q;
  assign csel_n_o   = csel_n_q;
  assign rx_valid_o = rx_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      csel_n_q   <= 1'b1;
      rx_valid_q <= 1'b0;
      mode_q     <= '0;
      div_q      <= '0;
    end else begin
      rx_valid_q <= finish;
      if (accept) begin
        busy_q   <= 1'b1;
        csel_n_q <= 1'b0;
        mode_q   <= '{pol: pol_i, pha: pha_i};
        div_q    <= clk_div_i;
      end else if (finish) begin
        busy_q   <= 1'b0;
        csel_n_q <= 1'b1;
      end
    end
  end

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .div  (div_q),
    .tick (tick)
  );

  spi_phase_ctrl #(.DATA_W(DATA_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .run     (busy_q),
    .tick    (tick),
    .pol_live(pol_i),
    .mode    (mode_q),
    .sclk_o  (sclk_o),
    .launch  (launch),
    .sample  (sample),
    .finish  (finish)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .early    (!pha_i),
    .load_data(tx_data_i),
    .launch   (launch),
    .sample   (sample),
    .miso_i   (miso_i),
    .mosi_o   (mosi_o),
    .shreg_o  (rx_data_o)
  );

  // R2: select stays asserted while the stream port is closed
  p_busy_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready_o |-> !csel_n_o);

  // R7: completion strobe lasts one clock
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R7: select release coincides with completion
  p_sel_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csel_n_o) |-> rx_valid_o);

  // R8: captured settings hold until the transfer closes
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish) |=> ($stable(mode_q) && $stable(div_q)));

  // R6: with pha=0 the top bit is on the line once select asserts
  p_first_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pha_i) |=> (mosi_o == $past(tx_data_i[DATA_W-1])));

endmodule

// File: tb/test_spi_xfer_master.sv
module test_spi_xfer_master;

  localparam int W  = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pol_i = 1'b0, pha_i = 1'b0;
  logic [DW-1:0] clk_div_i = '0;
  logic          tx_valid_i = 1'b0;
  logic          tx_ready_o;
  logic [W-1:0]  tx_data_i = '0;
  logic          rx_valid_o;
  logic [W-1:0]  rx_data_o;
  logic          sclk_o, mosi_o, csel_n_o;
  logic          miso_i = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_xfer_master #(.DATA_W(W), .DIV_W(DW)) i_spi_xfer_master (
    .clk(clk), .rst_n(rst_n), .pol_i(pol_i), .pha_i(pha_i),
    .clk_div_i(clk_div_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .tx_data_i(tx_data_i), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .csel_n_o(csel_n_o)
  );

  // Behavioural slave using the configuration the bench selected
  logic         s_pol, s_pha;
  logic [W-1:0] s_reply, s_got;
  int           s_edges, s_out;

  function automatic logic table_rising(logic p, logic h);
    case ({p, h})
      2'b00:   return 1'b1;
      2'b01:   return 1'b0;
      2'b10:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  always @(negedge csel_n_o) begin
    s_edges = 0;
    s_out   = 0;
    s_got   = '0;
    if (!s_pha) begin
      miso_i = s_reply[W-1];
      s_out  = 1;
    end
  end

  always @(sclk_o) begin
    if (!csel_n_o) begin
      s_edges++;
      if (sclk_o == table_rising(s_pol, s_pha)) begin
        s_got = {s_got[W-2:0], mosi_o};
      end else if (s_out < W) begin
        miso_i = s_reply[W-1-s_out];
        s_out++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic p, input logic h, input int d,
                      input logic [W-1:0] tx, input bit disturb);
    int n;
    int expn;
    logic [W-1:0] reply;
    reply = {tx[0], tx[W-1:1]} ^ 8'h3C;
    @(negedge clk);
    pol_i = p; pha_i = h; clk_div_i = DW'(d);
    s_pol = p; s_pha = h; s_reply = reply;
    @(negedge clk);
    check(sclk_o == p, "R1 idle clock level", sclk_o, p);
    check(tx_ready_o == 1'b1, "R1 ready while idle", tx_ready_o, 1);
    tx_valid_i = 1'b1; tx_data_i = tx;
    @(posedge clk);
    n = 0;
    expn = 17 * (d + 1) + 1;
    while (n < 2000) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        check(tx_ready_o == 1'b0 && csel_n_o == 1'b0, "R2 busy after accept",
              {tx_ready_o, csel_n_o}, 0);
        if (!h) check(mosi_o == tx[W-1], "R6 first bit before clock", mosi_o, tx[W-1]);
        if (disturb) begin
          pol_i = ~p; pha_i = ~h; clk_div_i = DW'(d + 2); tx_data_i = ~tx;
        end else begin
          tx_valid_i = 1'b0;
        end
      end
      if (rx_valid_o) break;
    end
    check(n == expn, "R7 transfer length", n, expn);
    check(csel_n_o == 1'b1, "R7 select released with done", csel_n_o, 1);
    check(s_got == tx, disturb ? "R8 slave byte under input change" : "R4 slave received byte",
          s_got, tx);
    check(rx_data_o == reply, disturb ? "R8 master byte under input change" : "R4 master received byte",
          rx_data_o, reply);
    check(s_edges == 16, "R5 clock transitions", s_edges, 16);
    check(sclk_o == pol_i, "R5 clock idle after transfer", sclk_o, pol_i);
    tx_valid_i = 1'b0;
    pol_i = p; pha_i = h; clk_div_i = DW'(d);
    @(negedge clk);
    check(rx_valid_o == 1'b0, "R7 done is one cycle", rx_valid_o, 0);
    check(csel_n_o == 1'b1 && tx_ready_o == 1'b1, "R2 no restart from ignored offer",
          {csel_n_o, tx_ready_o}, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h5A; pats[4] = 8'h80; pats[5] = 8'h01;
    s_pol = 1'b0; s_pha = 1'b0; s_reply = '0; s_got = '0;
    s_edges = 0; s_out = 0;
    repeat (3) @(negedge clk);
    check(csel_n_o == 1'b1 && rx_valid_o == 1'b0, "R1 reset outputs",
          {csel_n_o, rx_valid_o}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready_o == 1'b1, "R1 ready after reset", tx_ready_o, 1);
    pol_i = 1'b1;
    #1;
    check(sclk_o == 1'b1, "R1 clock follows polarity while idle", sclk_o, 1);
    for (int m = 0; m < 4; m++) begin
      for (int di = 0; di < 3; di++) begin
        for (int k = 0; k < 6; k++) begin
          xfer(m[1], m[0], (di == 2) ? 3 : di, pats[k], (k == 2));
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule